// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two IEEE 754 single-precision words. Each operand is split into sign, biased exponent (bias 127) and fraction, and the implicit leading one is put back. The operand of smaller magnitude is shifted right by the exponent difference. Three extra low-order positions (guard, round, sticky) keep track of the bits that fall off. The aligned significands are then added or subtracted. The raw result is normalized in one of two ways: a single right shift when a carry comes out, or a left shift by its leading-zero count when the operands cancel. It is rounded to nearest with ties to even, normalized again if rounding carried out, and packed back into a 32-bit word.

Zeros, infinities and NaNs are recognised from their exponent and fraction fields. Inputs with a zero exponent field are treated as zero, and results too small for a normal number are flushed to zero. The block is a two-stage pipeline. Stage one classifies, orders and aligns the operands. Stage two adds, normalizes, rounds and packs the result. The block accepts one operation per cycle, and each result leaves a registered output.

Top module: `fp_add_sp`

## Requirements
- R1: After reset, out_valid, result and overflow are 0. An operation presented with in_valid high appears on result with out_valid high exactly two rising edges later. Back-to-back operations are accepted every cycle and leave in order.
- R2: Two same-signed normal operands give their correctly rounded sum. When the significand sum reaches 2 or more, it is shifted right once and the exponent (bits 30:23) rises by one (1.5 + 1.5 = 0x40400000).
- R3: With op_sub = 1 the sign bit (bit 31) of op_b is inverted before the operation. The result sign is the sign of the operand with the larger magnitude.
- R4: When the operands cancel, the difference is left-shifted by its leading-zero count and the exponent is lowered by the same amount, with no loss of exactness (0x3F800001 − 0x3F800000 = 0x34000000).
- R5: Rounding is to nearest. An exact half-way case rounds to the value whose lowest fraction bit (bit 0) is 0. Any nonzero bit below the half-way position forces rounding away from zero.
- R6: If rounding carries out of the 24-bit significand, the fraction becomes 0 and the exponent rises by one (0x3FFFFFFF + 0x33800000 = 0x40000000).
- R7: If the final exponent reaches 255, the result is an infinity with the computed sign (exponent 255, fraction 0) and overflow is 1 in the same cycle. For every other result overflow is 0.
- R8: A NaN on either input (exponent 255, nonzero fraction), or the sum of opposite-signed infinities, gives the quiet NaN 0x7FC00000. An infinity combined with a finite value gives that infinity with its effective sign.
- R9: An exact zero from opposite-signed operands is +0 (0x00000000). The sum of two negative zeros is −0 (0x80000000). Inputs with exponent field 0 count as zero. A nonzero result below exponent 1 is flushed to a zero with the result sign.
- R10: When the exponent difference exceeds 26, the smaller operand contributes only to the sticky bit. It still decides rounding when the value lies just below a half-way point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and op_sub are valid this cycle |
| op_a | input | 32 | First operand, single-precision word |
| op_b | input | 32 | Second operand, single-precision word |
| op_sub | input | 1 | 1 = compute op_a − op_b, 0 = op_a + op_b |
| out_valid | output | 1 | result and overflow hold a new value |
| result | output | 32 | Rounded single-precision result |
| overflow | output | 1 | Result became infinity from finite operands |

## Verification
A wrong operand order or a lost sticky bit in the alignment stage shows up two cycles later in the lowest fraction bit. The directed half-way and just-past-half-way sums make that bit differ from the expected word. A leading-zero miscount moves both exponent and fraction on every cancelling subtraction, so the exact 2^-23 difference shows it at once. A wrong rounding carry shows only on an all-ones fraction, and the test that rounds up to 2.0 targets that case. Stale or misrouted special-case state corrupts the result on the NaN and infinity cases. The back-to-back stream catches any stage register that holds one operation while the next one passes through.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  // Extra low-order positions carried through alignment: guard, round, sticky
  localparam int GRS_W = 3;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fcls_e;
endpackage

// File: rtl/fpa_unpack.sv
module fpa_unpack
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word_i,
  input  logic                  flip_i,
  output logic                  sign_o,
  output logic [EXP_W-1:0]      exp_o,
  output logic [FRAC_W:0]       sig_o,
  output fcls_e                 cls_o
);
  localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};

  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;

  always_comb begin
    ex     = word_i[EXP_W+FRAC_W-1:FRAC_W];
    fr     = word_i[FRAC_W-1:0];
    sign_o = word_i[EXP_W+FRAC_W] ^ flip_i;
    if (ex == '0) begin
      // zero and denormal encodings are both flushed to zero
      cls_o = CLS_ZERO;
      exp_o = '0;
      sig_o = '0;
    end else begin
      exp_o = ex;
      sig_o = {1'b1, fr};
      if (ex == EXP_ONES) cls_o = (fr == '0) ? CLS_INF : CLS_NAN;
      else                cls_o = CLS_NORM;
    end
  end
endmodule

// File: rtl/fpa_align.sv
module fpa_align
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                      sign_a_i,
  input  logic [EXP_W-1:0]          exp_a_i,
  input  logic [FRAC_W:0]           sig_a_i,
  input  logic                      sign_b_i,
  input  logic [EXP_W-1:0]          exp_b_i,
  input  logic [FRAC_W:0]           sig_b_i,
  output logic [FRAC_W+GRS_W:0]     big_o,
  output logic [FRAC_W+GRS_W:0]     small_o,
  output logic [EXP_W-1:0]          exp_o,
  output logic                      sign_o
);
  localparam int MW  = FRAC_W + 1;
  localparam int XW  = MW + GRS_W;
  localparam int SHW = $clog2(XW + 1);

  logic             swap;
  logic [EXP_W-1:0] e_big, e_sml, diff;
  logic [MW-1:0]    m_big, m_sml;
  logic [SHW-1:0]   sh;
  logic [2*XW-1:0]  wide;

  always_comb begin
    // order by magnitude; ties keep operand a on top
    swap   = {exp_b_i, sig_b_i} > {exp_a_i, sig_a_i};
    e_big  = swap ? exp_b_i  : exp_a_i;
    e_sml  = swap ? exp_a_i  : exp_b_i;
    m_big  = swap ? sig_b_i  : sig_a_i;
    m_sml  = swap ? sig_a_i  : sig_b_i;
    sign_o = swap ? sign_b_i : sign_a_i;
    exp_o  = e_big;
    diff   = e_big - e_sml;
    // beyond XW positions nothing but sticky survives
    sh     = (diff > EXP_W'(XW)) ? SHW'(XW) : SHW'(diff);
    wide   = {m_sml, {GRS_W{1'b0}}, {XW{1'b0}}} >> sh;
    small_o = {wide[2*XW-1:XW+1], |wide[XW:0]};
    big_o   = {m_big, {GRS_W{1'b0}}};
  end
endmodule

// File: rtl/fpa_lzc.sv
module fpa_lzc #(
  parameter int W  = 27,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpa_normround.sv
module fpa_normround
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [FRAC_W+GRS_W:0]   big_i,
  input  logic [FRAC_W+GRS_W:0]   small_i,
  input  logic [EXP_W-1:0]        exp_i,
  input  logic                    sign_i,
  input  logic                    sub_i,
  output logic [EXP_W+FRAC_W:0]   word_o,
  output logic                    ovf_o
);
  localparam int MW  = FRAC_W + 1;
  localparam int XW  = MW + GRS_W;
  localparam int SW  = XW + 1;
  localparam int CW  = $clog2(XW + 1);
  localparam int EW2 = EXP_W + 2;
  localparam int EMAX = (1 << EXP_W) - 1;
  localparam logic signed [EW2-1:0] EMAX_S = EW2'(EMAX);
  localparam logic signed [EW2-1:0] ONE_S  = EW2'(1);

  logic [SW-1:0]           sum;
  logic [CW-1:0]           lz;
  logic [XW-1:0]           norm;
  logic signed [EW2-1:0]   exp_s, lz_s, e_n, e_r;
  logic                    rnd_up;
  logic [MW:0]             mant_r;
  logic [FRAC_W-1:0]       frac_r;

  assign sum = sub_i ? ({1'b0, big_i} - {1'b0, small_i})
                     : ({1'b0, big_i} + {1'b0, small_i});

  fpa_lzc #(.W(XW), .CW(CW)) u_lzc (
    .vec_i (sum[XW-1:0]),
    .cnt_o (lz)
  );

  always_comb begin
    exp_s = signed'({2'b00, exp_i});
    lz_s  = signed'(EW2'(lz));
    if (sum[XW]) begin
      // magnitudes added past 2.0: one step right, keep the lost bit as sticky
      norm = {sum[XW:2], sum[1] | sum[0]};
      e_n  = exp_s + ONE_S;
    end else begin
      norm = sum[XW-1:0] << lz;
      e_n  = exp_s - lz_s;
    end
    // nearest, ties to even: guard & (round | sticky | lsb)
    rnd_up = norm[2] & (norm[1] | norm[0] | norm[3]);
    mant_r = {1'b0, norm[XW-1:GRS_W]} + {{MW{1'b0}}, rnd_up};
    if (mant_r[MW]) begin
      e_r    = e_n + ONE_S;
      frac_r = '0;
    end else begin
      e_r    = e_n;
      frac_r = mant_r[FRAC_W-1:0];
    end

    ovf_o = 1'b0;
    if (sum == '0) begin
      word_o = {sub_i ? 1'b0 : sign_i, {(EXP_W+FRAC_W){1'b0}}};
    end else if (e_n < ONE_S) begin
      word_o = {sign_i, {(EXP_W+FRAC_W){1'b0}}};
    end else if (e_r >= EMAX_S) begin
      word_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      ovf_o  = 1'b1;
    end else begin
      word_o = {sign_i, e_r[EXP_W-1:0], frac_r};
    end
  end
endmodule

// File: rtl/fp_add_sp.sv
module fp_add_sp
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  input  logic                  op_sub,
  output logic                  out_valid,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  overflow
);
  localparam int W  = 1 + EXP_W + FRAC_W;
  localparam int MW = FRAC_W + 1;
  localparam int XW = MW + GRS_W;
  localparam logic [W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  // ---------------- stage 1: unpack, classify, align ----------------
  logic [W-1:0]     u_word [2];
  logic             u_flip [2];
  logic             u_sign [2];
  logic [EXP_W-1:0] u_exp  [2];
  logic [MW-1:0]    u_sig  [2];
  fcls_e            u_cls  [2];

  assign u_word[0] = op_a;
  assign u_word[1] = op_b;
  assign u_flip[0] = 1'b0;
  assign u_flip[1] = op_sub;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_unpack
      fpa_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
        .word_i (u_word[g]),
        .flip_i (u_flip[g]),
        .sign_o (u_sign[g]),
        .exp_o  (u_exp[g]),
        .sig_o  (u_sig[g]),
        .cls_o  (u_cls[g])
      );
    end
  endgenerate

  logic [XW-1:0]    al_big, al_small;
  logic [EXP_W-1:0] al_exp;
  logic             al_sign;

  fpa_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .sign_a_i (u_sign[0]),
    .exp_a_i  (u_exp[0]),
    .sig_a_i  (u_sig[0]),
    .sign_b_i (u_sign[1]),
    .exp_b_i  (u_exp[1]),
    .sig_b_i  (u_sig[1]),
    .big_o    (al_big),
    .small_o  (al_small),
    .exp_o    (al_exp),
    .sign_o   (al_sign)
  );

  logic         sp_hit;
  logic [W-1:0] sp_word;

  always_comb begin
    sp_hit  = 1'b1;
    sp_word = QNAN;
    if (u_cls[0] == CLS_NAN || u_cls[1] == CLS_NAN)
      sp_word = QNAN;
    else if (u_cls[0] == CLS_INF && u_cls[1] == CLS_INF)
      sp_word = (u_sign[0] != u_sign[1]) ? QNAN : {u_sign[0], INF_MAG};
    else if (u_cls[0] == CLS_INF)
      sp_word = {u_sign[0], INF_MAG};
    else if (u_cls[1] == CLS_INF)
      sp_word = {u_sign[1], INF_MAG};
    else
      sp_hit  = 1'b0;
  end

  logic             v1;
  logic [XW-1:0]    s1_big, s1_small;
  logic [EXP_W-1:0] s1_exp;
  logic             s1_sign, s1_sub, s1_spec;
  logic [W-1:0]     s1_spec_word;

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= in_valid;
    if (in_valid) begin
      s1_big       <= al_big;
      s1_small     <= al_small;
      s1_exp       <= al_exp;
      s1_sign      <= al_sign;
      s1_sub       <= u_sign[0] ^ u_sign[1];
      s1_spec      <= sp_hit;
      s1_spec_word <= sp_word;
    end
  end

  // aligned smaller operand never exceeds the larger one (R10 ordering)
  assert_align_order_R10: assert property (@(posedge clk) disable iff (rst)
    v1 |-> (s1_big >= s1_small));

  // ---------------- stage 2: add, normalize, round, pack ----------------
  logic [W-1:0] nr_word;
  logic         nr_ovf;

  fpa_normround #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nr (
    .big_i   (s1_big),
    .small_i (s1_small),
    .exp_i   (s1_exp),
    .sign_i  (s1_sign),
    .sub_i   (s1_sub),
    .word_o  (nr_word),
    .ovf_o   (nr_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      overflow  <= 1'b0;
    end else begin
      out_valid <= v1;
      if (v1) begin
        result   <= s1_spec ? s1_spec_word : nr_word;
        overflow <= s1_spec ? 1'b0 : nr_ovf;
      end
    end
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  assert_ovf_inf_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && overflow) |-> (result[W-2:0] == INF_MAG));

  assert_nan_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && result[W-2:FRAC_W] == {EXP_W{1'b1}} && result[FRAC_W-1:0] != '0)
      |-> (result == QNAN));

  assert_no_denorm_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && result[W-2:FRAC_W] == '0) |-> (result[FRAC_W-1:0] == '0));
endmodule

// File: tb/sim_fp_add_sp.sv
module sim_fp_add_sp;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        op_sub = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        overflow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fp_add_sp u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .op_sub(op_sub), .out_valid(out_valid), .result(result), .overflow(overflow)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // one operation, result sampled at the falling edge after two rising edges
  task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                        input logic sub, input logic [31:0] exp_res, input logic exp_ovf);
    @(negedge clk);
    op_a = a; op_b = b; op_sub = sub; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(req, {31'd0, out_valid}, 32'd1);
    check(req, result, exp_res);
    check(req, {31'd0, overflow}, {31'd0, exp_ovf});
    @(negedge clk);
    check(req, {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 reset valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset result", result, 32'd0);
    check("R1 reset overflow", {31'd0, overflow}, 32'd0);
  endtask

  task automatic t_add;
    run_op("R2 1+2", 32'h3F800000, 32'h40000000, 1'b0, 32'h40400000, 1'b0);
    run_op("R2 carry 1.5+1.5", 32'h3FC00000, 32'h3FC00000, 1'b0, 32'h40400000, 1'b0);
    run_op("R2 neg -1+-2", 32'hBF800000, 32'hC0000000, 1'b0, 32'hC0400000, 1'b0);
  endtask

  task automatic t_sub;
    run_op("R3 3-1", 32'h40400000, 32'h3F800000, 1'b1, 32'h40000000, 1'b0);
    run_op("R3 1-3", 32'h3F800000, 32'h40400000, 1'b1, 32'hC0000000, 1'b0);
    run_op("R3 1-(-2)", 32'h3F800000, 32'hC0000000, 1'b1, 32'h40400000, 1'b0);
  endtask

  task automatic t_cancel;
    run_op("R4 ulp diff", 32'h3F800001, 32'h3F800000, 1'b1, 32'h34000000, 1'b0);
    run_op("R4 1.5-1", 32'h3FC00000, 32'hBF800000, 1'b0, 32'h3F000000, 1'b0);
  endtask

  task automatic t_round;
    run_op("R5 tie to even down", 32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 1'b0);
    run_op("R5 tie to even up", 32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 1'b0);
    run_op("R5 past half", 32'h3F800000, 32'h33800080, 1'b0, 32'h3F800001, 1'b0);
  endtask

  task automatic t_renorm;
    run_op("R6 round to 2.0", 32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 1'b0);
  endtask

  task automatic t_overflow;
    run_op("R7 pos ovf", 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 1'b1);
    run_op("R7 neg ovf", 32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF800000, 1'b1);
  endtask

  task automatic t_special;
    run_op("R8 qnan in", 32'h7FC00000, 32'h3F800000, 1'b0, 32'h7FC00000, 1'b0);
    run_op("R8 snan in", 32'h3F800000, 32'h7F800001, 1'b0, 32'h7FC00000, 1'b0);
    run_op("R8 inf-inf", 32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, 1'b0);
    run_op("R8 inf+1", 32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000, 1'b0);
    run_op("R8 1-inf", 32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, 1'b0);
  endtask

  task automatic t_zero;
    run_op("R9 x-x", 32'h40400000, 32'h40400000, 1'b1, 32'h00000000, 1'b0);
    run_op("R9 -0+-0", 32'h80000000, 32'h80000000, 1'b0, 32'h80000000, 1'b0);
    run_op("R9 denorm in", 32'h00000001, 32'h3F800000, 1'b0, 32'h3F800000, 1'b0);
    run_op("R9 denorm pair", 32'h00400000, 32'h00400000, 1'b0, 32'h00000000, 1'b0);
    run_op("R9 underflow flush", 32'h00800001, 32'h00800000, 1'b1, 32'h00000000, 1'b0);
  endtask

  task automatic t_align;
    run_op("R10 far add", 32'h3F800000, 32'h30800000, 1'b0, 32'h3F800000, 1'b0);
    run_op("R10 far sub", 32'h3F800000, 32'h30800000, 1'b1, 32'h3F800000, 1'b0);
    run_op("R10 far sub small", 32'h30800000, 32'h3F800000, 1'b1, 32'hBF800000, 1'b0);
  endtask

  task automatic t_stream;
    logic [31:0] sa [4];
    logic [31:0] sb [4];
    logic [31:0] se [4];
    sa = '{32'h3F800000, 32'h40400000, 32'h3F800001, 32'h7F7FFFFF};
    sb = '{32'h40000000, 32'h3F800000, 32'h33800000, 32'h7F7FFFFF};
    se = '{32'h40400000, 32'h40800000, 32'h3F800002, 32'h7F800000};
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        check("R1 stream valid", {31'd0, out_valid}, 32'd1);
        check("R1 stream result", result, se[k-2]);
      end
      if (k < 4) begin
        op_a = sa[k]; op_b = sb[k]; op_sub = 1'b0; in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    check("R1 stream drained", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_reset();
    t_add();
    t_sub();
    t_cancel();
    t_round();
    t_renorm();
    t_overflow();
    t_special();
    t_zero();
    t_align();
    t_stream();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule